// File: doc/BRIEF.md
# Reaction Time Measurement Controller

This block runs a simple reaction test. A press on the start button arms it. The red lamp then lights for a fixed delay. After that the green lamp lights and a counter runs until the user presses the react button. The count then stops, and a slice of it stays on an 8-bit output that feeds a two-digit hex display until the next start. A press of react while the red lamp is still lit is a false start. It leaves the display showing all ones (FF on the digits).

One wide counter does both jobs. Arming loads it with the two's-complement negative of the delay length. It counts up through the delay, and the move to measuring happens when it rolls over to zero. From there it keeps counting up as the reaction time. It saturates at its maximum if nobody reacts. Both buttons go through a synchronizer and are edge-detected, so a button held down acts only once.

Top module: `rvt_reaction_timer`

## Requirements
- R1: After the active-low reset `rst_n` is released, the block is idle. Both lamps are off, the internal counter is zero and `time_disp` reads 0.
- R2: A start rising edge while idle moves the block into the delay phase. The red lamp lights and `time_disp` reads 0.
- R3: The delay phase lasts exactly WAIT_CYCLES clocks. The block then enters the measuring phase with the counter at zero and the green lamp lit.
- R4: During measuring, the counter increases by one every clock. `time_disp` equals counter bits [DISP_LSB+DISP_W-1:DISP_LSB].
- R5: A react rising edge during measuring returns the block to idle. The counter holds its value, so `time_disp` stays frozen.
- R6: A react rising edge during the delay phase is a false start. The counter is set to all ones and the block returns to idle, so `time_disp` reads all ones (255).
- R7: The red lamp is on only in the delay phase and the green lamp only in the measuring phase. They are never on together.
- R8: `time_disp` is 0 throughout the delay phase, even when the previous result was nonzero.
- R9: During measuring, the counter stops at its all-ones maximum and does not wrap.
- R10: A start edge outside idle has no effect, and a react edge in idle has no effect. A frozen result stays on `time_disp` until the next start.
- R11: Each button passes through a SYNC_STAGES-deep synchronizer (default 2) and acts only on its rising edge. With the default depth, the lamps change after the third rising clock edge following the input going high. A held button acts only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_btn | input | 1 | Start button, asynchronous to clk |
| react_btn | input | 1 | React button, asynchronous to clk |
| led_red | output | 1 | Lit during the delay phase |
| led_green | output | 1 | Lit during the measuring phase |
| time_disp | output | DISP_W (8) | Counter slice for the display, zero during the delay phase |

## Verification
The bench goes after the following corner cases:
- The exact delay length. A design off by one in the preload or the rollover test gives a red phase one clock too long or too short.
- The first measured value. A design that skipped the rollover would start measuring from a nonzero count.
- A false start. It must read 255 and must clear to zero on the next start. A design that forgot the forced load would show a stale or partial count.
- A run left to overflow. A wrapping counter would drop back to small values while the green lamp is still lit.
- Buttons held for many clocks, and presses in the wrong phase. A level-sensitive design would re-arm or drop a frozen result.

// File: rtl/rvt_pkg.sv
package rvt_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WAIT  = 2'd1,
      ST_COUNT = 2'd2
   } rvt_state_e;

   typedef enum logic [2:0] {
      OP_HOLD    = 3'd0,
      OP_PRELOAD = 3'd1,
      OP_STEP    = 3'd2,
      OP_RUN     = 3'd3,
      OP_FLAG    = 3'd4
   } rvt_cnt_op_e;

endpackage

// File: rtl/rvt_btn_edge.sv
module rvt_btn_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic btn,
   output logic rise
);

   localparam int CHAIN_W = STAGES + 1;

   logic [CHAIN_W-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("rvt_btn_edge: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         chain_q <= {chain_q[CHAIN_W-2:0], btn};
      end
   end

   assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];

endmodule

// File: rtl/rvt_cnt.sv
module rvt_cnt
   import rvt_pkg::*;
#(
   parameter int CNT_W       = 28,
   parameter int WAIT_CYCLES = 187_500_000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  rvt_cnt_op_e       op,
   output logic [CNT_W-1:0]  cnt,
   output logic              at_top
);

   localparam logic [CNT_W-1:0] WAIT_V  = CNT_W'(WAIT_CYCLES);
   localparam logic [CNT_W-1:0] PRELOAD = ~WAIT_V + 1'b1;

   logic [CNT_W-1:0] cnt_q;

   assign at_top = &cnt_q;
   assign cnt    = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else begin
         unique case (op)
            OP_PRELOAD: cnt_q <= PRELOAD;
            OP_STEP:    cnt_q <= cnt_q + 1'b1;
            OP_RUN:     if (!at_top) cnt_q <= cnt_q + 1'b1;
            OP_FLAG:    cnt_q <= '1;
            default:    cnt_q <= cnt_q;
         endcase
      end
   end

endmodule

// File: rtl/rvt_ctrl.sv
module rvt_ctrl
   import rvt_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start_rise,
   input  logic        react_rise,
   input  logic        cnt_top,
   output rvt_state_e  state,
   output rvt_cnt_op_e op
);

   rvt_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      op      = OP_HOLD;
      unique case (state_q)
         ST_IDLE: begin
            if (start_rise) begin
               state_d = ST_WAIT;
               op      = OP_PRELOAD;
            end
         end
         ST_WAIT: begin
            if (react_rise) begin
               state_d = ST_IDLE;
               op      = OP_FLAG;
            end else begin
               op = OP_STEP;
               if (cnt_top) state_d = ST_COUNT;
            end
         end
         ST_COUNT: begin
            if (react_rise) begin
               state_d = ST_IDLE;
               op      = OP_HOLD;
            end else begin
               op = OP_RUN;
            end
         end
         default: begin
            state_d = ST_IDLE;
            op      = OP_HOLD;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign state = state_q;

endmodule

// File: rtl/rvt_reaction_timer.sv
module rvt_reaction_timer
   import rvt_pkg::*;
#(
   parameter int CNT_W       = 28,
   parameter int WAIT_CYCLES = 187_500_000,
   parameter int DISP_LSB    = 16,
   parameter int DISP_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_btn,
   input  logic              react_btn,
   output logic              led_red,
   output logic              led_green,
   output logic [DISP_W-1:0] time_disp
);

   localparam int DISP_MSB = DISP_LSB + DISP_W - 1;

   generate
      if (DISP_MSB >= CNT_W) begin : g_bad_slice
         $error("rvt_reaction_timer: display slice exceeds counter width");
      end
      if (WAIT_CYCLES < 1) begin : g_bad_wait
         $error("rvt_reaction_timer: WAIT_CYCLES must be positive");
      end
      if (CNT_W < 31 && WAIT_CYCLES >= (1 << CNT_W)) begin : g_bad_wait_w
         $error("rvt_reaction_timer: WAIT_CYCLES does not fit the counter");
      end
   endgenerate

   logic             start_rise, react_rise;
   logic             cnt_top;
   logic [CNT_W-1:0] cnt_q;
   rvt_state_e       state;
   rvt_cnt_op_e      cnt_op;

   rvt_btn_edge #(.STAGES(SYNC_STAGES)) u_start_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .btn   (start_btn),
      .rise  (start_rise)
   );

   rvt_btn_edge #(.STAGES(SYNC_STAGES)) u_react_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .btn   (react_btn),
      .rise  (react_rise)
   );

   rvt_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_rise (start_rise),
      .react_rise (react_rise),
      .cnt_top    (cnt_top),
      .state      (state),
      .op         (cnt_op)
   );

   rvt_cnt #(.CNT_W(CNT_W), .WAIT_CYCLES(WAIT_CYCLES)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .op     (cnt_op),
      .cnt    (cnt_q),
      .at_top (cnt_top)
   );

   assign led_red   = (state == ST_WAIT);
   assign led_green = (state == ST_COUNT);
   assign time_disp = (state == ST_WAIT) ? '0 : cnt_q[DISP_MSB:DISP_LSB];

endmodule

// File: rtl/rvt_checker.sv
module rvt_checker #(
   parameter int CNT_W  = 28,
   parameter int DISP_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              led_red,
   input logic              led_green,
   input logic [DISP_W-1:0] time_disp,
   input logic [CNT_W-1:0]  cnt
);

   AST_LAMPS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(led_red && led_green)); // R7

   AST_WAIT_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
      led_red |-> (time_disp == '0)); // R8

   AST_GREEN_AFTER_RED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(led_green) |-> $past(led_red)); // R3

   AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (led_green && $past(led_green)) |-> (cnt >= $past(cnt))); // R9

   AST_FALSE_START_FF: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(led_red) && !led_green) |-> (&time_disp)); // R6

   AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!led_red && !led_green && $past(!led_red && !led_green)) |-> $stable(time_disp)); // R10

endmodule

bind rvt_reaction_timer rvt_checker #(.CNT_W(CNT_W), .DISP_W(DISP_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .led_red   (led_red),
   .led_green (led_green),
   .time_disp (time_disp),
   .cnt       (cnt_q)
);

// File: tb/tb_rvt_reaction_timer.sv
`timescale 1ns/1ps
module tb_rvt_reaction_timer;

   localparam int CNT_W    = 12;
   localparam int WAIT_CYC = 50;
   localparam int DISP_LSB = 2;
   localparam int DISP_W   = 8;
   localparam int MODV     = 1 << CNT_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_btn = 1'b0;
   logic react_btn = 1'b0;
   logic led_red, led_green;
   logic [DISP_W-1:0] time_disp;

   int n_chk = 0;
   int n_fail = 0;
   int cycles = 0;
   bit chk_en = 1'b0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   rvt_reaction_timer #(
      .CNT_W(CNT_W), .WAIT_CYCLES(WAIT_CYC), .DISP_LSB(DISP_LSB),
      .DISP_W(DISP_W), .SYNC_STAGES(2)
   ) dut (
      .clk(clk), .rst_n(rst_n), .start_btn(start_btn), .react_btn(react_btn),
      .led_red(led_red), .led_green(led_green), .time_disp(time_disp)
   );

   task automatic check(string tag, int act, int exp, string what);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   // Behavioural reference: 0 idle, 1 delay, 2 measuring
   int m_state = 0;
   int m_cnt = 0;
   bit st_q[$] = '{1'b0, 1'b0, 1'b0};
   bit rc_q[$] = '{1'b0, 1'b0, 1'b0};
   bit m_sp, m_rp;

   always @(posedge clk) begin
      cycles++;
      if (!rst_n) begin
         m_state = 0;
         m_cnt = 0;
         st_q = '{1'b0, 1'b0, 1'b0};
         rc_q = '{1'b0, 1'b0, 1'b0};
      end else begin
         m_sp = st_q[1] && !st_q[2];
         m_rp = rc_q[1] && !rc_q[2];
         case (m_state)
            0: if (m_sp) begin m_state = 1; m_cnt = MODV - WAIT_CYC; end
            1: if (m_rp) begin m_state = 0; m_cnt = MODV - 1; end
               else if (m_cnt == MODV - 1) begin m_state = 2; m_cnt = 0; end
               else m_cnt++;
            default: if (m_rp) m_state = 0;
               else if (m_cnt < MODV - 1) m_cnt++;
         endcase
         st_q.push_front(start_btn); void'(st_q.pop_back());
         rc_q.push_front(react_btn); void'(rc_q.pop_back());
      end
   end

   always @(negedge clk) begin
      if (chk_en && !done) begin
         check("R7", int'({led_red, led_green}),
               int'({m_state == 1, m_state == 2}), "lamps vs model");
         if (m_state == 1)
            check("R8", int'(time_disp), 0, "display in delay vs model");
         else if (m_state == 2)
            check("R4", int'(time_disp), (m_cnt >> DISP_LSB) & 255, "display measuring vs model");
         else
            check("R5", int'(time_disp), (m_cnt >> DISP_LSB) & 255, "display idle vs model");
      end
   end

   always @(posedge clk) begin
      if (cycles == 100000 && !done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   task automatic wait_lamp(bit red);
      for (int i = 0; i < 6000; i++) begin
         if ((red ? led_red : led_green) == 1'b1) break;
         @(negedge clk);
      end
   endtask

   initial begin
      int n;
      logic [DISP_W-1:0] held;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk_en = 1'b1;
      @(negedge clk);
      check("R1", int'({led_red, led_green}), 0, "lamps after reset");
      check("R1", int'(time_disp), 0, "display after reset");

      // react in idle is ignored
      react_btn = 1'b1; repeat (2) @(negedge clk); react_btn = 1'b0;
      repeat (6) @(negedge clk);
      check("R10", int'({led_red, led_green, time_disp}), 0, "react in idle");

      // start latency
      start_btn = 1'b1;
      @(negedge clk); check("R11", int'(led_red), 0, "red after 1 edge");
      @(negedge clk); check("R11", int'(led_red), 0, "red after 2 edges");
      @(negedge clk); check("R11", int'(led_red), 1, "red after 3 edges");
      check("R2", int'(time_disp), 0, "display at arm");
      n = 0;
      while (led_red) begin
         n++;
         if (n == 10) start_btn = 1'b0;
         if (n == 20) start_btn = 1'b1;
         if (n == 24) start_btn = 1'b0;
         if (n > 1000) break;
         @(negedge clk);
      end
      check("R3", n, WAIT_CYC, "delay length in clocks");
      check("R3", int'(led_green), 1, "green after delay");
      check("R3", int'(time_disp), 0, "first measured value");
      repeat (40) @(negedge clk);
      check("R4", int'(time_disp), 40 >> DISP_LSB, "display after 40 clocks");

      // start during measuring is ignored
      start_btn = 1'b1; repeat (3) @(negedge clk); start_btn = 1'b0;
      repeat (200) @(negedge clk);
      check("R10", int'(led_green), 1, "start while measuring");

      // react, held long
      react_btn = 1'b1;
      repeat (3) @(negedge clk);
      check("R5", int'(led_green), 0, "green off after react");
      held = time_disp;
      repeat (30) @(negedge clk);
      react_btn = 1'b0;
      repeat (10) @(negedge clk);
      check("R5", int'(time_disp), int'(held), "frozen result");
      check("R11", int'({led_red, led_green}), 0, "held react acts once");

      // false start
      start_btn = 1'b1; repeat (3) @(negedge clk); start_btn = 1'b0;
      wait_lamp(1'b1);
      repeat (10) @(negedge clk);
      react_btn = 1'b1; repeat (3) @(negedge clk); react_btn = 1'b0;
      check("R6", int'({led_red, led_green}), 0, "idle after false start");
      check("R6", int'(time_disp), 255, "false start display");
      react_btn = 1'b1; repeat (3) @(negedge clk); react_btn = 1'b0;
      repeat (5) @(negedge clk);
      check("R10", int'(time_disp), 255, "react in idle keeps flag");

      // rearm clears display, then overflow run
      start_btn = 1'b1; repeat (3) @(negedge clk); start_btn = 1'b0;
      wait_lamp(1'b1);
      check("R8", int'(time_disp), 0, "display cleared on rearm");
      wait_lamp(1'b0);
      repeat (MODV + 100) @(negedge clk);
      check("R9", int'(led_green), 1, "still measuring at top");
      check("R9", int'(time_disp), 255, "saturated display");
      react_btn = 1'b1; repeat (3) @(negedge clk); react_btn = 1'b0;
      repeat (4) @(negedge clk);
      check("R5", int'({led_red, led_green, time_disp}), 255, "idle after saturated run");

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule